// File: doc/BRIEF.md
# Processor exception condition detector

This block sits next to the execute stage of a 32-bit processor and decides, for each instruction, whether it raises one of three faults. The faults are a divide error, a data access at an address that does not suit the access width, and an indirect control transfer to a target that is not word aligned. The pipeline presents the instruction's class flags, its access width, the data address, the transfer target and the divide operands with their signedness. The detection is combinational. A registered capture stage then reports the accepted fault one cycle later.

For an accepted fault, the capture stage writes a five-bit cause code and, for the two alignment faults, the offending address. Three enable inputs configure the block. One turns on the divide check, one turns on both alignment checks, and one turns on the recording of cause and address. A build parameter states whether a hardware divider exists. Without one, the divide check is removed entirely.

The class flags are independent bits, so a fused operation may assert more than one of them. When several faults coincide, a fixed priority chooses the one that is reported.

Top module: `excp_cond_detect`

## Requirements
- R1: With hardware divide present and `en_div_chk` high, a valid instruction with `is_div` high and `div_b` equal to zero raises a fault with cause 5'd10. This holds whether `div_signed` is high or low.
- R2: A signed divide (`div_signed`=1) of 32'h8000_0000 by 32'hFFFF_FFFF raises cause 5'd10. The same operands with `div_signed`=0, and a signed divide of 32'h8000_0000 by 1, raise nothing.
- R3: For a valid load or store with `en_align_chk` high, a misaligned data address raises cause 5'd8. The width code `mem_size` is 0 for byte, 1 for half-word, 2 for word, and 3 is treated as word. A word access is misaligned when address bits [1:0] are not zero, and a half-word access when bit 0 is set. A byte access never faults. The captured address is `data_addr`.
- R4: A valid instruction with `is_jump` high and `en_align_chk` high, whose `jump_target` has bits [1:0] not zero, raises cause 5'd9. The captured address is `jump_target`.
- R5: When `en_div_chk` is low, no divide fault is raised. When `en_align_chk` is low, neither alignment fault is raised. In both cases `exc_valid` stays low and the recorded cause and address keep their values.
- R6: When several faults are present on one instruction, the cause recorded is chosen in this order: misaligned target (9) first, then misaligned data (8), then divide (10).
- R7: `exc_valid` is high in the cycle after an instruction is accepted, meaning `instr_valid` is high and a fault is detected. It is low in every other cycle. An instruction with `instr_valid` low never raises `exc_valid`.
- R8: With `en_cause_rec` high, `exc_cause` and `bad_addr` change only on an accepted fault. A divide fault updates `exc_cause` but leaves `bad_addr` unchanged.
- R9: With `en_cause_rec` low, an accepted fault still raises `exc_valid`, but `exc_cause` and `bad_addr` keep their previous values.
- R10: A synchronous active-high `rst` clears `exc_valid`, `exc_cause` and `bad_addr` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Instruction in execute is valid |
| is_load | input | 1 | Instruction reads data memory |
| is_store | input | 1 | Instruction writes data memory |
| is_div | input | 1 | Instruction is a divide |
| is_jump | input | 1 | Instruction is a register-indirect transfer (branch, call, jump, return, exception or breakpoint return) |
| mem_size | input | 2 | Access width code: 0 byte, 1 half, 2 or 3 word |
| data_addr | input | 32 | Computed data byte address |
| jump_target | input | 32 | Computed transfer target byte address |
| div_a | input | 32 | Dividend |
| div_b | input | 32 | Divisor |
| div_signed | input | 1 | Divide is signed |
| en_div_chk | input | 1 | Enables the divide error check |
| en_align_chk | input | 1 | Enables both alignment checks |
| en_cause_rec | input | 1 | Enables recording of cause and faulting address |
| exc_valid | output | 1 | Registered fault report, one cycle after acceptance |
| exc_cause | output | 5 | Recorded cause code |
| bad_addr | output | 32 | Recorded faulting address |

## Verification
The divide check is driven with a zero divisor under both signednesses, and with the minimum-negative-by-minus-one pair under both signednesses. This separates the zero test from the overflow test, and it separates the signed path from the unsigned one. A signed minimum divided by one confirms that overflow requires both operands. Data addresses are swept across every low-bit pattern that matters for each width, so that each width's mask is exercised on its own; transfer targets are driven both aligned and off by two. Finally, faults are stacked on a single instruction and the three enables are turned off one at a time, which shows the priority order and also shows that recording can be switched off independently of reporting.

// File: rtl/excp_pkg.sv
package excp_pkg;
   localparam int CAUSE_W = 5;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2,
      SZ_WIDE = 2'd3
   } mem_size_e;

   localparam logic [CAUSE_W-1:0] CAUSE_NONE      = 5'd0;
   localparam logic [CAUSE_W-1:0] CAUSE_MISAL_DAT = 5'd8;
   localparam logic [CAUSE_W-1:0] CAUSE_MISAL_DST = 5'd9;
   localparam logic [CAUSE_W-1:0] CAUSE_DIV_ERR   = 5'd10;
endpackage

// File: rtl/excp_div_check.sv
module excp_div_check #(
   parameter int XLEN      = 32,
   parameter bit HW_DIVIDE = 1'b1
) (
   input  logic [XLEN-1:0] dvd,
   input  logic [XLEN-1:0] dvs,
   input  logic            sgn,
   output logic            err
);
   localparam logic [XLEN-1:0] MOST_NEG = {1'b1, {(XLEN-1){1'b0}}};
   localparam logic [XLEN-1:0] MINUS_1  = {XLEN{1'b1}};

   generate
      if (HW_DIVIDE) begin : g_div
         logic zero_dvs, ovf;
         always_comb begin
            zero_dvs = (dvs == '0);
            ovf      = sgn && (dvd == MOST_NEG) && (dvs == MINUS_1);
            err      = zero_dvs || ovf;
         end
      end else begin : g_nodiv
         logic unused_ok;
         always_comb begin
            unused_ok = ^{dvd, dvs, sgn};
            err       = 1'b0 & unused_ok;
         end
      end
   endgenerate
endmodule

// File: rtl/excp_align_check.sv
module excp_align_check
   import excp_pkg::*;
#(
   parameter int XLEN       = 32,
   parameter int INSTR_ALGN = 2
) (
   input  logic [XLEN-1:0] daddr,
   input  mem_size_e       dsize,
   input  logic [XLEN-1:0] taddr,
   output logic            data_mis,
   output logic            dest_mis
);
   localparam int MAX_LG = 2;
   localparam logic [XLEN-1:0] TMASK = XLEN'((1 << INSTR_ALGN) - 1);

   function automatic logic [XLEN-1:0] low_mask(input mem_size_e s);
      int lg;
      lg = (int'(s) > MAX_LG) ? MAX_LG : int'(s);
      return XLEN'((1 << lg) - 1);
   endfunction

   always_comb begin
      data_mis = |(daddr & low_mask(dsize));
      dest_mis = |(taddr & TMASK);
   end
endmodule

// File: rtl/excp_capture.sv
module excp_capture
   import excp_pkg::*;
#(
   parameter int XLEN = 32
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               vld,
   input  logic               hit_dst,
   input  logic               hit_dat,
   input  logic               hit_div,
   input  logic               rec_en,
   input  logic [XLEN-1:0]    daddr,
   input  logic [XLEN-1:0]    taddr,
   output logic               exc_q,
   output logic [CAUSE_W-1:0] cause_q,
   output logic [XLEN-1:0]    addr_q
);
   logic               accept;
   logic [CAUSE_W-1:0] cause_d;
   logic [XLEN-1:0]    addr_d;

   always_comb begin
      accept  = vld && (hit_dst || hit_dat || hit_div);
      cause_d = cause_q;
      addr_d  = addr_q;
      if (hit_dst) begin
         cause_d = CAUSE_MISAL_DST;
         addr_d  = taddr;
      end else if (hit_dat) begin
         cause_d = CAUSE_MISAL_DAT;
         addr_d  = daddr;
      end else if (hit_div) begin
         cause_d = CAUSE_DIV_ERR;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         exc_q   <= 1'b0;
         cause_q <= CAUSE_NONE;
         addr_q  <= '0;
      end else begin
         exc_q <= accept;
         if (accept && rec_en) begin
            cause_q <= cause_d;
            addr_q  <= addr_d;
         end
      end
   end
endmodule

// File: rtl/excp_cond_detect.sv
module excp_cond_detect
   import excp_pkg::*;
#(
   parameter int XLEN       = 32,
   parameter bit HW_DIVIDE  = 1'b1,
   parameter int INSTR_ALGN = 2
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               instr_valid,
   input  logic               is_load,
   input  logic               is_store,
   input  logic               is_div,
   input  logic               is_jump,
   input  logic [1:0]         mem_size,
   input  logic [XLEN-1:0]    data_addr,
   input  logic [XLEN-1:0]    jump_target,
   input  logic [XLEN-1:0]    div_a,
   input  logic [XLEN-1:0]    div_b,
   input  logic               div_signed,
   input  logic               en_div_chk,
   input  logic               en_align_chk,
   input  logic               en_cause_rec,
   output logic               exc_valid,
   output logic [CAUSE_W-1:0] exc_cause,
   output logic [XLEN-1:0]    bad_addr
);
   generate
      if (XLEN < 16) begin : g_bad_xlen
         $error("excp_cond_detect: XLEN must be at least 16");
      end
      if (INSTR_ALGN < 1 || INSTR_ALGN > 3) begin : g_bad_algn
         $error("excp_cond_detect: INSTR_ALGN out of range");
      end
   endgenerate

   logic div_err, data_mis, dest_mis;
   logic hit_div, hit_dat, hit_dst;

   excp_div_check #(.XLEN(XLEN), .HW_DIVIDE(HW_DIVIDE)) u_div (
      .dvd (div_a),
      .dvs (div_b),
      .sgn (div_signed),
      .err (div_err)
   );

   excp_align_check #(.XLEN(XLEN), .INSTR_ALGN(INSTR_ALGN)) u_algn (
      .daddr    (data_addr),
      .dsize    (mem_size_e'(mem_size)),
      .taddr    (jump_target),
      .data_mis (data_mis),
      .dest_mis (dest_mis)
   );

   always_comb begin
      hit_div = en_div_chk && is_div && div_err;
      hit_dat = en_align_chk && (is_load || is_store) && data_mis;
      hit_dst = en_align_chk && is_jump && dest_mis;
   end

   excp_capture #(.XLEN(XLEN)) u_cap (
      .clk     (clk),
      .rst     (rst),
      .vld     (instr_valid),
      .hit_dst (hit_dst),
      .hit_dat (hit_dat),
      .hit_div (hit_div),
      .rec_en  (en_cause_rec),
      .daddr   (data_addr),
      .taddr   (jump_target),
      .exc_q   (exc_valid),
      .cause_q (exc_cause),
      .addr_q  (bad_addr)
   );
endmodule

// File: rtl/excp_cond_detect_chk.sv
module excp_cond_detect_chk #(
   parameter int XLEN       = 32,
   parameter bit HW_DIVIDE  = 1'b1,
   parameter int INSTR_ALGN = 2
) (
   input logic            clk,
   input logic            rst,
   input logic            instr_valid,
   input logic            is_load,
   input logic            is_store,
   input logic            is_div,
   input logic            is_jump,
   input logic [1:0]      mem_size,
   input logic [XLEN-1:0] jump_target,
   input logic [XLEN-1:0] div_b,
   input logic            en_div_chk,
   input logic            en_align_chk,
   input logic            en_cause_rec,
   input logic            exc_valid,
   input logic [4:0]      exc_cause,
   input logic [XLEN-1:0] bad_addr
);
   p_div_zero_r1: assert property (@(posedge clk) disable iff (rst)
      (HW_DIVIDE && instr_valid && is_div && en_div_chk && div_b == '0) |=> exc_valid);

   p_byte_never_r3: assert property (@(posedge clk) disable iff (rst)
      (instr_valid && (is_load || is_store) && mem_size == 2'd0 && !is_div && !is_jump)
      |=> !exc_valid);

   p_dest_capture_r4: assert property (@(posedge clk) disable iff (rst)
      (instr_valid && is_jump && en_align_chk && en_cause_rec && jump_target[1:0] != 2'b00)
      |=> (exc_cause == 5'd9 && bad_addr == $past(jump_target)));

   p_align_off_r5: assert property (@(posedge clk) disable iff (rst)
      (!en_align_chk && !is_div) |=> !exc_valid);

   p_needs_valid_r7: assert property (@(posedge clk) disable iff (rst)
      !instr_valid |=> !exc_valid);

   p_hold_idle_r8: assert property (@(posedge clk) disable iff (rst)
      !instr_valid |=> ($stable(exc_cause) && $stable(bad_addr)));

   p_hold_norec_r9: assert property (@(posedge clk) disable iff (rst)
      !en_cause_rec |=> ($stable(exc_cause) && $stable(bad_addr)));

   p_reset_clear_r10: assert property (@(posedge clk)
      rst |=> (!exc_valid && exc_cause == 5'd0 && bad_addr == '0));
endmodule

bind excp_cond_detect excp_cond_detect_chk #(
   .XLEN(XLEN), .HW_DIVIDE(HW_DIVIDE), .INSTR_ALGN(INSTR_ALGN)
) u_chk (.*);

// File: tb/excp_cond_detect_tb.sv
module excp_cond_detect_tb;
   localparam int CLK_PERIOD = 10;
   localparam int WD_CYCLES  = 5000;

   logic        clk = 1'b0;
   logic        rst;
   logic        instr_valid, is_load, is_store, is_div, is_jump;
   logic [1:0]  mem_size;
   logic [31:0] data_addr, jump_target, div_a, div_b;
   logic        div_signed, en_div_chk, en_align_chk, en_cause_rec;
   logic        exc_valid;
   logic [4:0]  exc_cause;
   logic [31:0] bad_addr;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   excp_cond_detect u_dut (.*);

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s got=%h exp=%h", tag, got, exp);
      end
   endtask

   task automatic idle_inputs();
      instr_valid = 0; is_load = 0; is_store = 0; is_div = 0; is_jump = 0;
      mem_size = 2'd0; data_addr = '0; jump_target = '0;
      div_a = 32'd7; div_b = 32'd3; div_signed = 0;
   endtask

   // drive at negedge, cross one posedge, sample at the next negedge
   task automatic issue(input logic v, ld, st, dv, jp, input logic [1:0] sz,
                        input logic [31:0] da, ta, a, b, input logic sg);
      instr_valid = v; is_load = ld; is_store = st; is_div = dv; is_jump = jp;
      mem_size = sz; data_addr = da; jump_target = ta;
      div_a = a; div_b = b; div_signed = sg;
      @(negedge clk);
      idle_inputs();
   endtask

   task automatic t_reset();
      rst = 1; idle_inputs();
      en_div_chk = 1; en_align_chk = 1; en_cause_rec = 1;
      repeat (2) @(negedge clk);
      chk("R10 valid after reset", 32'(exc_valid), 0);
      chk("R10 cause after reset", 32'(exc_cause), 0);
      chk("R10 addr after reset", bad_addr, 0);
      rst = 0;
   endtask

   task automatic t_div_zero();
      issue(1,0,0,1,0,0, 32'h0, 32'h0, 32'd55, 32'd0, 0);
      chk("R1 unsigned /0 valid", 32'(exc_valid), 1);
      chk("R1 unsigned /0 cause", 32'(exc_cause), 10);
      chk("R8 div keeps addr", bad_addr, 0);
      @(negedge clk);
      chk("R7 pulse drops", 32'(exc_valid), 0);
      issue(1,0,0,1,0,0, 32'h0, 32'h0, 32'hFFFF_FFF0, 32'd0, 1);
      chk("R1 signed /0 valid", 32'(exc_valid), 1);
   endtask

   task automatic t_div_ovf();
      issue(1,0,0,1,0,0, 0, 0, 32'h8000_0000, 32'hFFFF_FFFF, 1);
      chk("R2 signed ovf valid", 32'(exc_valid), 1);
      chk("R2 signed ovf cause", 32'(exc_cause), 10);
      issue(1,0,0,1,0,0, 0, 0, 32'h8000_0000, 32'hFFFF_FFFF, 0);
      chk("R2 unsigned same ops", 32'(exc_valid), 0);
      issue(1,0,0,1,0,0, 0, 0, 32'h8000_0000, 32'd1, 1);
      chk("R2 min by one", 32'(exc_valid), 0);
      issue(1,0,0,1,0,0, 0, 0, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 1);
      chk("R2 max by minus one", 32'(exc_valid), 0);
   endtask

   task automatic t_data_align();
      for (int sz = 0; sz < 4; sz++) begin
         for (int lo = 0; lo < 4; lo++) begin
            logic [31:0] a;
            bit exp_f;
            a = 32'h0001_2340 | 32'(lo);
            exp_f = (sz == 0) ? 1'b0 : (sz == 1) ? (lo[0] != 0) : (lo != 0);
            issue(1, (lo % 2 == 0), (lo % 2 == 1), 0, 0, 2'(sz), a, 0, 7, 3, 0);
            chk($sformatf("R3 size%0d low%0d valid", sz, lo), 32'(exc_valid), 32'(exp_f));
            if (exp_f) begin
               chk("R3 data cause", 32'(exc_cause), 8);
               chk("R3 data addr", bad_addr, a);
            end
         end
      end
   endtask

   task automatic t_dest_align();
      issue(1,0,0,0,1,0, 32'h0, 32'h4000_0006, 7, 3, 0);
      chk("R4 target valid", 32'(exc_valid), 1);
      chk("R4 target cause", 32'(exc_cause), 9);
      chk("R4 target addr", bad_addr, 32'h4000_0006);
      issue(1,0,0,0,1,0, 32'h0, 32'h4000_0008, 7, 3, 0);
      chk("R4 aligned target", 32'(exc_valid), 0);
      chk("R8 addr unchanged", bad_addr, 32'h4000_0006);
   endtask

   task automatic t_enables();
      en_align_chk = 0;
      issue(1,1,0,0,0,2, 32'h0000_1003, 0, 7, 3, 0);
      chk("R5 align off data", 32'(exc_valid), 0);
      issue(1,0,0,0,1,0, 0, 32'h0000_2001, 7, 3, 0);
      chk("R5 align off target", 32'(exc_valid), 0);
      chk("R5 addr held", bad_addr, 32'h4000_0006);
      en_align_chk = 1; en_div_chk = 0;
      issue(1,0,0,1,0,0, 0, 0, 32'd9, 32'd0, 0);
      chk("R5 div off", 32'(exc_valid), 0);
      chk("R5 cause held", 32'(exc_cause), 9);
      en_div_chk = 1;
   endtask

   task automatic t_priority();
      issue(1,1,0,1,1,2, 32'h0000_0502, 32'h0000_0A01, 32'd1, 32'd0, 0);
      chk("R6 all three cause", 32'(exc_cause), 9);
      chk("R6 all three addr", bad_addr, 32'h0000_0A01);
      issue(1,0,1,1,0,1, 32'h0000_0611, 32'h0, 32'd1, 32'd0, 0);
      chk("R6 data over div cause", 32'(exc_cause), 8);
      chk("R6 data over div addr", bad_addr, 32'h0000_0611);
      issue(1,1,0,1,1,2, 32'h0000_0700, 32'h0000_0800, 32'd1, 32'd0, 0);
      chk("R6 only div left", 32'(exc_cause), 10);
      chk("R6 div keeps addr", bad_addr, 32'h0000_0611);
   endtask

   task automatic t_no_record();
      en_cause_rec = 0;
      issue(1,0,0,0,1,0, 0, 32'h0000_0C02, 7, 3, 0);
      chk("R9 valid still", 32'(exc_valid), 1);
      chk("R9 cause held", 32'(exc_cause), 10);
      chk("R9 addr held", bad_addr, 32'h0000_0611);
      en_cause_rec = 1;
   endtask

   task automatic t_invalid();
      issue(0,1,0,1,1,2, 32'h0000_0003, 32'h0000_0003, 32'd1, 32'd0, 0);
      chk("R7 invalid no valid", 32'(exc_valid), 0);
      chk("R7 invalid cause held", 32'(exc_cause), 10);
      chk("R7 invalid addr held", bad_addr, 32'h0000_0611);
   endtask

   task automatic t_reset_mid();
      rst = 1;
      @(negedge clk);
      chk("R10 mid valid", 32'(exc_valid), 0);
      chk("R10 mid cause", 32'(exc_cause), 0);
      chk("R10 mid addr", bad_addr, 0);
      rst = 0;
   endtask

   initial begin
      @(negedge clk);
      t_reset();
      t_div_zero();
      t_div_ovf();
      t_data_align();
      t_dest_align();
      t_enables();
      t_priority();
      t_no_record();
      t_invalid();
      t_reset_mid();
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (WD_CYCLES) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog expired got=running exp=finished");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end
endmodule